// File: doc/BRIEF.md
# Out-of-Order Instruction Window

The instruction window holds decoded instructions between dispatch and retirement in an out-of-order pipeline. It has twelve slots kept in no fixed order. Each slot records an operation code, a destination tag, two source tags each with a ready flag, a two-bit lifecycle state, a NOP flag and a saturating age counter. The decoder writes each new instruction into the lowest-numbered free slot. When no slot is free the window raises a stall that holds fetch and decode.

Each slot passes through READ, EXECUTE and WRITE-BACK before it becomes free again. The issue, execute and write-back stages move a slot forward by returning its slot number. When a non-NOP slot retires, its destination tag is broadcast as a result. Every slot that is waiting in READ on a matching source marks that source ready.

A jump can request a flush by naming its own slot. Every occupied slot that is younger than the jump becomes a NOP. A NOP slot in READ drains one per cycle, lowest slot first: it presents both source tags so that the per-register pending counters outside the window can be decremented, and then goes straight to FREE. A NOP slot that is already past READ runs to the end but broadcasts no result. An issue stage reads the fields of a slot through a combinational read port.

Top module: `iw_window`

## Requirements
- R1: After reset every slot is FREE (state code 0), `disp_stall` is 0, `disp_slot` is 0, `ready_mask` and `nop_mask` are 0, and `rd_age` reads 0.
- R2: When `disp_valid` is high and `disp_stall` is low, the instruction is written into the slot shown on `disp_slot`. That slot is the lowest-numbered FREE slot, and it enters READ (code 1) with age 0. `rd_*` returns the stored fields, and stale fields stay readable after the slot is freed. A `rd_slot` of 12 or more reads all zeros.
- R3: `disp_stall` is high exactly when no slot is FREE. A dispatch offered while the stall is high changes no slot.
- R4: State codes are FREE=0, READ=1, EXECUTE=2 and WRITE-BACK=3, packed two bits per slot in `state_flat`, with slot i at bits [2i+1:2i]. `issue_slot` moves a slot from READ to EXECUTE only if that slot is ready. `wb_enter_slot` moves a slot from EXECUTE to WRITE-BACK. `retire_slot` moves a slot from WRITE-BACK to FREE. A slot number that names a slot in any other state, or that is 12 or more, is ignored.
- R5: `ready_mask[i]` is high exactly when slot i is in READ, is not a NOP, and has both source ready flags set.
- R6: A result broadcast sets the ready flag of every source of a READ slot whose tag equals the broadcast tag. The broadcast also applies to an instruction dispatched in the same cycle.
- R7: `res_valid` is high, with `res_tag` equal to the stored destination, in the cycle in which a non-NOP slot in WRITE-BACK is retired. A retiring NOP gives no result.
- R8: A slot's age is 0 in the cycle after it is allocated. It then rises by one per clock while the slot stays occupied, holds at 63, and reads 0 once the slot is freed.
- R9: On `flush_valid` with `flush_slot` naming an occupied slot, every occupied slot whose age is strictly below that slot's age gets its bit set in `nop_mask` from the next cycle. The jump itself and an instruction dispatched in the same cycle are not flushed.
- R10: While any slot is a NOP in READ, `drain_valid` is high and `drain_src1`/`drain_src2` carry the source tags of the lowest-numbered such slot. That slot becomes FREE at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Decoder offers an instruction |
| disp_op | input | 4 | Operation code |
| disp_dst | input | 4 | Destination tag |
| disp_src1 | input | 4 | First source tag |
| disp_src1_ok | input | 1 | First source already available |
| disp_src2 | input | 4 | Second source tag |
| disp_src2_ok | input | 1 | Second source already available |
| disp_stall | output | 1 | No free slot; hold fetch and decode |
| disp_slot | output | 4 | Slot the next dispatch will take |
| issue_valid | input | 1 | Issue stage starts a slot |
| issue_slot | input | 4 | Slot moving READ to EXECUTE |
| wb_enter_valid | input | 1 | Execute stage finishes a slot |
| wb_enter_slot | input | 4 | Slot moving EXECUTE to WRITE-BACK |
| retire_valid | input | 1 | Write-back stage finishes a slot |
| retire_slot | input | 4 | Slot leaving WRITE-BACK |
| res_valid | output | 1 | Result broadcast this cycle |
| res_tag | output | 4 | Broadcast destination tag |
| flush_valid | input | 1 | Jump requests a flush |
| flush_slot | input | 4 | Slot holding the jump |
| drain_valid | output | 1 | A NOP slot releases its sources |
| drain_src1 | output | 4 | First released source tag |
| drain_src2 | output | 4 | Second released source tag |
| ready_mask | output | 12 | Slots ready to issue |
| nop_mask | output | 12 | Slots marked NOP |
| state_flat | output | 24 | Packed two-bit slot states |
| rd_slot | input | 4 | Read port slot select |
| rd_op | output | 4 | Stored operation |
| rd_dst | output | 4 | Stored destination |
| rd_src1 | output | 4 | Stored first source |
| rd_src1_ok | output | 1 | First source ready flag |
| rd_src2 | output | 4 | Stored second source |
| rd_src2_ok | output | 1 | Second source ready flag |
| rd_age | output | 6 | Stored age |

## Verification
A slot whose state is wrong shows up in `state_flat` at the very next clock. It then spreads within a cycle or two into the wrong `disp_slot`, a wrong `disp_stall`, or a `ready_mask` bit that is missing. A lost wakeup keeps a ready bit low forever. A bad age comparison on flush shows up as a wrong `nop_mask` in the cycle after the jump, and then as a drain sequence in the wrong order or with the wrong length on `drain_src1`/`drain_src2`. Comparing every output against a slot-level model in every cycle catches each of these within the cycle it first becomes visible.

// File: rtl/iw_pkg.sv
package iw_pkg;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_READ = 2'd1,
    ST_EXEC = 2'd2,
    ST_WB   = 2'd3
  } iw_state_e;

  // Lifecycle step: each advance adds one, WRITE-BACK wraps to FREE.
  function automatic iw_state_e st_next(input iw_state_e s);
    logic [1:0] raw;
    raw = s + 2'd1;
    return iw_state_e'(raw);
  endfunction

  // A broadcast tag hits a waiting source.
  function automatic logic tag_hit(input logic en, input logic [7:0] a,
                                   input logic [7:0] b);
    return en && (a == b);
  endfunction

endpackage

// File: rtl/iw_lowest_pick.sv
module iw_lowest_pick #(
  parameter int N     = 12,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/iw_slot.sv
module iw_slot
  import iw_pkg::*;
#(
  parameter int OP_W  = 4,
  parameter int TAG_W = 4,
  parameter int AGE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OP_W-1:0]  ld_op,
  input  logic [TAG_W-1:0] ld_dst,
  input  logic [TAG_W-1:0] ld_src1,
  input  logic             ld_ok1,
  input  logic [TAG_W-1:0] ld_src2,
  input  logic             ld_ok2,
  input  logic             wake_valid,
  input  logic [TAG_W-1:0] wake_tag,
  input  logic             issue_hit,
  input  logic             wbent_hit,
  input  logic             retire_hit,
  input  logic             drain_hit,
  input  logic             flush_valid,
  input  logic [AGE_W-1:0] flush_age,
  output iw_state_e        state_o,
  output logic             nop_o,
  output logic             ready_o,
  output logic [AGE_W-1:0] age_o,
  output logic [OP_W-1:0]  op_o,
  output logic [TAG_W-1:0] dst_o,
  output logic [TAG_W-1:0] src1_o,
  output logic             ok1_o,
  output logic [TAG_W-1:0] src2_o,
  output logic             ok2_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  iw_state_e        state_q;
  logic             nop_q;
  logic [AGE_W-1:0] age_q;
  logic [OP_W-1:0]  op_q;
  logic [TAG_W-1:0] dst_q, src1_q, src2_q;
  logic             ok1_q, ok2_q;

  // Named internal events
  logic             flush_hit;
  logic             wake1, wake2;
  logic             ld_wake1, ld_wake2;
  logic [AGE_W-1:0] age_bump;

  assign flush_hit = flush_valid && (state_q != ST_FREE) && (age_q < flush_age);
  assign wake1     = tag_hit(wake_valid, 8'(src1_q), 8'(wake_tag));
  assign wake2     = tag_hit(wake_valid, 8'(src2_q), 8'(wake_tag));
  assign ld_wake1  = tag_hit(wake_valid, 8'(ld_src1), 8'(wake_tag));
  assign ld_wake2  = tag_hit(wake_valid, 8'(ld_src2), 8'(wake_tag));
  assign age_bump  = (age_q == AGE_MAX) ? age_q : age_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FREE;
      nop_q   <= 1'b0;
      age_q   <= '0;
      op_q    <= '0;
      dst_q   <= '0;
      src1_q  <= '0;
      src2_q  <= '0;
      ok1_q   <= 1'b0;
      ok2_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_FREE: begin
          if (load) begin
            state_q <= ST_READ;
            nop_q   <= 1'b0;
            age_q   <= '0;
            op_q    <= ld_op;
            dst_q   <= ld_dst;
            src1_q  <= ld_src1;
            src2_q  <= ld_src2;
            ok1_q   <= ld_ok1 | ld_wake1;
            ok2_q   <= ld_ok2 | ld_wake2;
          end
        end
        ST_READ: begin
          if (drain_hit) begin
            state_q <= ST_FREE;
            nop_q   <= 1'b0;
            age_q   <= '0;
          end else begin
            if (issue_hit && ready_o) state_q <= ST_EXEC;
            if (wake1) ok1_q <= 1'b1;
            if (wake2) ok2_q <= 1'b1;
            if (flush_hit) nop_q <= 1'b1;
            age_q <= age_bump;
          end
        end
        ST_EXEC: begin
          if (wbent_hit) state_q <= ST_WB;
          if (flush_hit) nop_q <= 1'b1;
          age_q <= age_bump;
        end
        default: begin
          if (retire_hit) begin
            state_q <= ST_FREE;
            nop_q   <= 1'b0;
            age_q   <= '0;
          end else begin
            if (flush_hit) nop_q <= 1'b1;
            age_q <= age_bump;
          end
        end
      endcase
    end
  end

  assign state_o = state_q;
  assign nop_o   = nop_q;
  assign ready_o = (state_q == ST_READ) && !nop_q && ok1_q && ok2_q;
  assign age_o   = age_q;
  assign op_o    = op_q;
  assign dst_o   = dst_q;
  assign src1_o  = src1_q;
  assign ok1_o   = ok1_q;
  assign src2_o  = src2_q;
  assign ok2_o   = ok2_q;

  // R4: a slot moves one step forward, or drops from READ straight to FREE
  a_r4_state_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |->
      ((state_q == st_next($past(state_q))) ||
       ($past(state_q) == ST_READ && state_q == ST_FREE)));

  // R8: an occupied slot ages by one per clock, holding at the top value
  a_r8_age_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != ST_FREE && state_q != ST_FREE) |->
      (($past(age_q) == AGE_MAX) ? (age_q == AGE_MAX)
                                 : (age_q == $past(age_q) + 1'b1)));

  // R9: a NOP mark is kept until the slot is freed
  a_r9_nop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(nop_q) && $past(state_q) != ST_FREE && state_q != ST_FREE) |-> nop_q);

endmodule

// File: rtl/iw_window.sv
module iw_window
  import iw_pkg::*;
#(
  parameter int N_SLOTS = 12,
  parameter int OP_W    = 4,
  parameter int TAG_W   = 4,
  parameter int AGE_W   = 6,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_valid,
  input  logic [OP_W-1:0]      disp_op,
  input  logic [TAG_W-1:0]     disp_dst,
  input  logic [TAG_W-1:0]     disp_src1,
  input  logic                 disp_src1_ok,
  input  logic [TAG_W-1:0]     disp_src2,
  input  logic                 disp_src2_ok,
  output logic                 disp_stall,
  output logic [IDX_W-1:0]     disp_slot,
  input  logic                 issue_valid,
  input  logic [IDX_W-1:0]     issue_slot,
  input  logic                 wb_enter_valid,
  input  logic [IDX_W-1:0]     wb_enter_slot,
  input  logic                 retire_valid,
  input  logic [IDX_W-1:0]     retire_slot,
  output logic                 res_valid,
  output logic [TAG_W-1:0]     res_tag,
  input  logic                 flush_valid,
  input  logic [IDX_W-1:0]     flush_slot,
  output logic                 drain_valid,
  output logic [TAG_W-1:0]     drain_src1,
  output logic [TAG_W-1:0]     drain_src2,
  output logic [N_SLOTS-1:0]   ready_mask,
  output logic [N_SLOTS-1:0]   nop_mask,
  output logic [2*N_SLOTS-1:0] state_flat,
  input  logic [IDX_W-1:0]     rd_slot,
  output logic [OP_W-1:0]      rd_op,
  output logic [TAG_W-1:0]     rd_dst,
  output logic [TAG_W-1:0]     rd_src1,
  output logic                 rd_src1_ok,
  output logic [TAG_W-1:0]     rd_src2,
  output logic                 rd_src2_ok,
  output logic [AGE_W-1:0]     rd_age
);
  iw_state_e        st_a   [N_SLOTS];
  logic [AGE_W-1:0] age_a  [N_SLOTS];
  logic [OP_W-1:0]  op_a   [N_SLOTS];
  logic [TAG_W-1:0] dst_a  [N_SLOTS];
  logic [TAG_W-1:0] s1_a   [N_SLOTS];
  logic [TAG_W-1:0] s2_a   [N_SLOTS];
  logic             ok1_a  [N_SLOTS];
  logic             ok2_a  [N_SLOTS];
  logic [N_SLOTS-1:0] free_req, drain_req, nop_v, ready_v;

  // Named internal events
  logic             free_found;
  logic             disp_fire;
  logic             drain_found;
  logic [IDX_W-1:0] drain_idx;
  logic             retire_in, flush_in, rd_in;
  logic             flush_en;
  logic [AGE_W-1:0] flush_age;

  assign retire_in = int'(retire_slot) < N_SLOTS;
  assign flush_in  = int'(flush_slot) < N_SLOTS;
  assign rd_in     = int'(rd_slot) < N_SLOTS;

  iw_lowest_pick #(.N(N_SLOTS), .IDX_W(IDX_W)) u_free_pick (
    .req(free_req), .found(free_found), .idx(disp_slot));

  iw_lowest_pick #(.N(N_SLOTS), .IDX_W(IDX_W)) u_drain_pick (
    .req(drain_req), .found(drain_found), .idx(drain_idx));

  assign disp_stall = !free_found;
  assign disp_fire  = disp_valid && free_found;

  assign res_valid = retire_valid && retire_in &&
                     (st_a[retire_in ? retire_slot : '0] == ST_WB) &&
                     !nop_v[retire_in ? retire_slot : '0];
  assign res_tag   = dst_a[retire_in ? retire_slot : '0];

  assign flush_en  = flush_valid && flush_in &&
                     (st_a[flush_in ? flush_slot : '0] != ST_FREE);
  assign flush_age = age_a[flush_in ? flush_slot : '0];

  assign drain_valid = drain_found;
  assign drain_src1  = s1_a[drain_idx];
  assign drain_src2  = s2_a[drain_idx];

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    iw_state_e st_w;
    logic      nop_w, rdy_w, ok1_w, ok2_w;

    iw_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (disp_fire && disp_slot == IDX_W'(i)),
      .ld_op      (disp_op),
      .ld_dst     (disp_dst),
      .ld_src1    (disp_src1),
      .ld_ok1     (disp_src1_ok),
      .ld_src2    (disp_src2),
      .ld_ok2     (disp_src2_ok),
      .wake_valid (res_valid),
      .wake_tag   (res_tag),
      .issue_hit  (issue_valid && issue_slot == IDX_W'(i)),
      .wbent_hit  (wb_enter_valid && wb_enter_slot == IDX_W'(i)),
      .retire_hit (retire_valid && retire_slot == IDX_W'(i)),
      .drain_hit  (drain_found && drain_idx == IDX_W'(i)),
      .flush_valid(flush_en),
      .flush_age  (flush_age),
      .state_o    (st_w),
      .nop_o      (nop_w),
      .ready_o    (rdy_w),
      .age_o      (age_a[i]),
      .op_o       (op_a[i]),
      .dst_o      (dst_a[i]),
      .src1_o     (s1_a[i]),
      .ok1_o      (ok1_w),
      .src2_o     (s2_a[i]),
      .ok2_o      (ok2_w)
    );

    assign st_a[i]       = st_w;
    assign ok1_a[i]      = ok1_w;
    assign ok2_a[i]      = ok2_w;
    assign nop_v[i]      = nop_w;
    assign ready_v[i]    = rdy_w;
    assign free_req[i]   = (st_w == ST_FREE);
    assign drain_req[i]  = (st_w == ST_READ) && nop_w;
    assign state_flat[2*i +: 2] = st_w;
  end

  assign ready_mask = ready_v;
  assign nop_mask   = nop_v;

  assign rd_op      = rd_in ? op_a[rd_slot]  : '0;
  assign rd_dst     = rd_in ? dst_a[rd_slot] : '0;
  assign rd_src1    = rd_in ? s1_a[rd_slot]  : '0;
  assign rd_src1_ok = rd_in ? ok1_a[rd_slot] : 1'b0;
  assign rd_src2    = rd_in ? s2_a[rd_slot]  : '0;
  assign rd_src2_ok = rd_in ? ok2_a[rd_slot] : 1'b0;
  assign rd_age     = rd_in ? age_a[rd_slot] : '0;

  // R2: an accepted dispatch lands in READ in the slot that was offered
  a_r2_alloc_lands: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> (st_a[$past(disp_slot)] == ST_READ));

  // R10: the drained slot is free one clock later
  a_r10_drain_frees: assert property (@(posedge clk) disable iff (!rst_n)
    drain_found |=> (st_a[$past(drain_idx)] == ST_FREE));

  // R7: a broadcast comes only from a retire request
  a_r7_result_source: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> retire_valid);

endmodule

// File: tb/iw_window_tb.sv
module iw_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 12;
  localparam int IW  = 4;
  localparam int AMX = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic disp_valid, disp_src1_ok, disp_src2_ok;
  logic [3:0] disp_op, disp_dst, disp_src1, disp_src2;
  logic disp_stall;
  logic [IW-1:0] disp_slot;
  logic issue_valid, wb_enter_valid, retire_valid, flush_valid;
  logic [IW-1:0] issue_slot, wb_enter_slot, retire_slot, flush_slot, rd_slot;
  logic res_valid, drain_valid;
  logic [3:0] res_tag, drain_src1, drain_src2;
  logic [N-1:0] ready_mask, nop_mask;
  logic [2*N-1:0] state_flat;
  logic [3:0] rd_op, rd_dst, rd_src1, rd_src2;
  logic rd_src1_ok, rd_src2_ok;
  logic [5:0] rd_age;

  iw_window dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
    .disp_src1(disp_src1), .disp_src1_ok(disp_src1_ok),
    .disp_src2(disp_src2), .disp_src2_ok(disp_src2_ok),
    .disp_stall(disp_stall), .disp_slot(disp_slot),
    .issue_valid(issue_valid), .issue_slot(issue_slot),
    .wb_enter_valid(wb_enter_valid), .wb_enter_slot(wb_enter_slot),
    .retire_valid(retire_valid), .retire_slot(retire_slot),
    .res_valid(res_valid), .res_tag(res_tag),
    .flush_valid(flush_valid), .flush_slot(flush_slot),
    .drain_valid(drain_valid), .drain_src1(drain_src1), .drain_src2(drain_src2),
    .ready_mask(ready_mask), .nop_mask(nop_mask), .state_flat(state_flat),
    .rd_slot(rd_slot), .rd_op(rd_op), .rd_dst(rd_dst),
    .rd_src1(rd_src1), .rd_src1_ok(rd_src1_ok),
    .rd_src2(rd_src2), .rd_src2_ok(rd_src2_ok), .rd_age(rd_age)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Slot-level model of the requirements
  int m_st[N], m_nop[N], m_age[N], m_op[N], m_dst[N];
  int m_s1[N], m_v1[N], m_s2[N], m_v2[N];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int is_ready(input int i);
    return (m_st[i] == 1 && m_nop[i] == 0 && m_v1[i] != 0 && m_v2[i] != 0) ? 1 : 0;
  endfunction

  // kind: 0 ready, 1 exec, 2 write-back, 3 occupied; returns -1 if none
  function automatic int pick(input int kind);
    int cnt = 0;
    int k;
    bit ok;
    for (int i = 0; i < N; i++) begin
      ok = (kind == 0) ? (is_ready(i) != 0) : (kind == 3) ? (m_st[i] != 0) : (m_st[i] == kind + 1);
      if (ok) cnt++;
    end
    if (cnt == 0) return -1;
    k = $urandom % cnt;
    for (int i = 0; i < N; i++) begin
      ok = (kind == 0) ? (is_ready(i) != 0) : (kind == 3) ? (m_st[i] != 0) : (m_st[i] == kind + 1);
      if (ok) begin
        if (k == 0) return i;
        k--;
      end
    end
    return -1;
  endfunction

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (m_st[i] == 0) return i;
    return -1;
  endfunction

  function automatic int lowest_drain();
    for (int i = 0; i < N; i++) if (m_st[i] == 1 && m_nop[i] != 0) return i;
    return -1;
  endfunction

  function automatic int slot_or_rand(input int k);
    if (k >= 0 && ($urandom % 4) != 0) return k;
    return $urandom % 16;
  endfunction

  task automatic drive(input int pd, input int pi, input int pw, input int pr, input int pf);
    disp_valid     = ($urandom % 100) < pd;
    disp_op        = 4'($urandom);
    disp_dst       = 4'($urandom);
    disp_src1      = 4'($urandom);
    disp_src2      = 4'($urandom);
    disp_src1_ok   = ($urandom % 2) != 0;
    disp_src2_ok   = ($urandom % 3) == 0;
    issue_valid    = ($urandom % 100) < pi;
    issue_slot     = 4'(slot_or_rand(pick(0)));
    wb_enter_valid = ($urandom % 100) < pw;
    wb_enter_slot  = 4'(slot_or_rand(pick(1)));
    retire_valid   = ($urandom % 100) < pr;
    retire_slot    = 4'(slot_or_rand(pick(2)));
    flush_valid    = ($urandom % 100) < pf;
    flush_slot     = 4'(slot_or_rand(pick(3)));
    rd_slot        = 4'($urandom % 14);
  endtask

  task automatic compare_and_advance();
    int lf, ld, rs, fs, rd, fage;
    bit fire, rv;
    logic [2*N-1:0] est;
    logic [N-1:0] erdy, enop;
    int n_st[N], n_nop[N], n_age[N], n_v1[N], n_v2[N];
    lf = lowest_free();
    ld = lowest_drain();
    check("R3 stall", disp_stall, lf < 0);
    if (lf >= 0) check("R2 lowest free slot", disp_slot, lf);
    rs = int'(retire_slot);
    rv = retire_valid && rs < N && m_st[rs] == 3 && m_nop[rs] == 0;
    check("R7 result valid", res_valid, rv);
    if (rv) check("R7 result tag", res_tag, m_dst[rs]);
    check("R10 drain valid", drain_valid, ld >= 0);
    if (ld >= 0) begin
      check("R10 drain src1", drain_src1, m_s1[ld]);
      check("R10 drain src2", drain_src2, m_s2[ld]);
    end
    for (int i = 0; i < N; i++) begin
      est[2*i +: 2] = 2'(m_st[i]);
      erdy[i] = is_ready(i) != 0;
      enop[i] = m_nop[i] != 0;
    end
    check("R4 state vector", state_flat, est);
    check("R5 ready mask", ready_mask, erdy);
    check("R9 nop mask", nop_mask, enop);
    rd = int'(rd_slot);
    if (rd < N) begin
      check("R2 read fields", {rd_op, rd_dst, rd_src1, rd_src2},
            {4'(m_op[rd]), 4'(m_dst[rd]), 4'(m_s1[rd]), 4'(m_s2[rd])});
      check("R6 ready flags", {rd_src1_ok, rd_src2_ok}, {m_v1[rd] != 0, m_v2[rd] != 0});
      check("R8 age", rd_age, m_age[rd]);
    end else begin
      check("R2 out of range read", {rd_op, rd_dst, rd_src1, rd_src2, rd_src1_ok, rd_src2_ok, rd_age}, 0);
    end

    // next model state
    fs = int'(flush_slot);
    fage = (flush_valid && fs < N && m_st[fs] != 0) ? m_age[fs] : -1;
    fire = disp_valid && lf >= 0;
    for (int i = 0; i < N; i++) begin
      bit fh;
      n_st[i] = m_st[i]; n_nop[i] = m_nop[i]; n_age[i] = m_age[i];
      n_v1[i] = m_v1[i]; n_v2[i] = m_v2[i];
      fh = (fage >= 0) && m_st[i] != 0 && m_age[i] < fage;
      case (m_st[i])
        0: if (fire && i == lf) begin
             n_st[i] = 1; n_nop[i] = 0; n_age[i] = 0;
             m_op[i] = disp_op; m_dst[i] = disp_dst; m_s1[i] = disp_src1; m_s2[i] = disp_src2;
             n_v1[i] = (disp_src1_ok || (rv && disp_src1 == 4'(m_dst[rs]))) ? 1 : 0;
             n_v2[i] = (disp_src2_ok || (rv && disp_src2 == 4'(m_dst[rs]))) ? 1 : 0;
           end
        1: if (i == ld) begin
             n_st[i] = 0; n_nop[i] = 0; n_age[i] = 0;
           end else begin
             if (issue_valid && int'(issue_slot) == i && is_ready(i) != 0) n_st[i] = 2;
             if (rv && m_s1[i] == m_dst[rs]) n_v1[i] = 1;
             if (rv && m_s2[i] == m_dst[rs]) n_v2[i] = 1;
             if (fh) n_nop[i] = 1;
             n_age[i] = (m_age[i] < AMX) ? m_age[i] + 1 : AMX;
           end
        2: begin
             if (wb_enter_valid && int'(wb_enter_slot) == i) n_st[i] = 3;
             if (fh) n_nop[i] = 1;
             n_age[i] = (m_age[i] < AMX) ? m_age[i] + 1 : AMX;
           end
        default:
           if (retire_valid && rs == i) begin
             n_st[i] = 0; n_nop[i] = 0; n_age[i] = 0;
           end else begin
             if (fh) n_nop[i] = 1;
             n_age[i] = (m_age[i] < AMX) ? m_age[i] + 1 : AMX;
           end
      endcase
    end
    for (int i = 0; i < N; i++) begin
      m_st[i] = n_st[i]; m_nop[i] = n_nop[i]; m_age[i] = n_age[i];
      m_v1[i] = n_v1[i]; m_v2[i] = n_v2[i];
    end
  endtask

  task automatic cycle(input int pd, input int pi, input int pw, input int pr, input int pf);
    @(negedge clk);
    drive(pd, pi, pw, pr, pf);
    #1;
    compare_and_advance();
  endtask

  initial begin
    void'($urandom(32'h1d5e_0042));
    for (int i = 0; i < N; i++) begin
      m_st[i] = 0; m_nop[i] = 0; m_age[i] = 0; m_op[i] = 0; m_dst[i] = 0;
      m_s1[i] = 0; m_v1[i] = 0; m_s2[i] = 0; m_v2[i] = 0;
    end
    disp_valid = 0; issue_valid = 0; wb_enter_valid = 0; retire_valid = 0; flush_valid = 0;
    disp_op = 0; disp_dst = 0; disp_src1 = 0; disp_src2 = 0; disp_src1_ok = 0; disp_src2_ok = 0;
    issue_slot = 0; wb_enter_slot = 0; retire_slot = 0; flush_slot = 0; rd_slot = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 reset states", state_flat, 0);
    check("R1 reset stall", disp_stall, 0);
    check("R1 reset slot", disp_slot, 0);
    check("R1 reset masks", {ready_mask, nop_mask}, 0);
    check("R1 reset age", rd_age, 0);
    // Fill to full and hold there: stall and blocked dispatch (R3)
    repeat (40) cycle(100, 0, 0, 0, 0);
    // Allocation heavy with slow drain of the pipeline
    repeat (400) cycle(90, 40, 30, 10, 0);
    // Balanced traffic with flushes (R6, R9, R10)
    repeat (2500) cycle(60, 60, 60, 60, 4);
    // Flush-heavy stretch
    repeat (400) cycle(70, 30, 30, 30, 15);
    // Age saturation: no advances (R8)
    repeat (6) cycle(100, 0, 0, 0, 0);
    repeat (90) cycle(0, 0, 0, 0, 0);
    // Drain everything out
    repeat (300) cycle(0, 80, 80, 80, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule